// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block keeps the interrupt bookkeeping of an SD-style host controller. Event pulses from the command, data and DMA engines of the host set sticky bits in a raw status word. A mask word and a global interrupt enable decide whether any pending bit drives the single, registered interrupt line. Software reads the raw and masked views through a 32-bit register port and clears bits by writing ones.

The block also follows a card-detect level. A rising edge records an insertion and a falling edge records a removal, and each of these flags clears the other. A card-present bit in a separate card status word follows the same edges. A remaining-transfer counter is loaded by software and counts down by a fixed access size on each data access, saturating at zero. When an access leaves it at zero, the block raises the data-complete bit on its own.

Top module: `sdh_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, raw status reads 0, card status reads 0x00000100, global control reads 0x00000300, the remaining counter reads 0, and `irq` is 0. Register word indices: 0 control, 1 counter, 2 mask, 3 masked status, 4 raw status, 5 card status. Other indices read 0 and ignore writes.
- R2: `irq` is a register. In each cycle it equals the previous cycle's value of (control bit 4) AND (OR of raw status AND mask), so it changes one cycle after status, mask or enable changes.
- R3: Reading index 3 returns raw AND mask. Reading index 4 returns raw status unmasked.
- R4: Writing to index 3 or index 4 clears every raw bit written as 1 and leaves all other raw bits unchanged.
- R5: A one-cycle event pulse sets its raw bit: bit 1 for no response, bit 2 for command complete, bit 3 for data complete, bit 14 for auto-stop done, bit 16 for SDIO/DMA done.
- R6: A rising edge of `card_detect` sets raw bit 30, clears raw bit 31 and sets card status bit 8. A falling edge sets bit 31, clears bit 30 and clears bit 8. The previous level resets to 1.
- R7: Writing index 1 loads the counter, and this load wins over an access in the same cycle. Each `xfer_access` pulse subtracts 4, saturating at 0. If the counter is 0 after that update, raw bit 3 is set.
- R8: Writing 1 to a card status bit clears that bit.
- R9: A write to control stores the written value with bits 2..0 forced to 0.
- R10: An event or card edge in the same cycle as a software clear of the same bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ev_no_resp | input | 1 | No-response event pulse |
| ev_cmd_done | input | 1 | Command-complete event pulse |
| ev_data_done | input | 1 | Data-complete event pulse |
| ev_autostop_done | input | 1 | Auto-stop-done event pulse |
| ev_sdio_done | input | 1 | SDIO/DMA-done event pulse |
| card_detect | input | 1 | Card-detect level |
| xfer_access | input | 1 | One data access of 4 bytes |
| irq | output | 1 | Interrupt line |

## Verification
The gating path is tested with single events, with several events at once, with the mask changed while bits are pending, and with the global enable switched off and on. These runs separate the raw view from the masked one and show the one-cycle lag of the line. Clears are sent through both status indices with partial patterns, and some land in the same cycle as a new event, which shows whether the clear or the event has priority. The counter is tested with a count that is not a multiple of the access size, with accesses at zero, and with a load in the same cycle as an access. These cases show whether it saturates, self-raises data complete and lets the load win. Card edges in both directions show that the insert and remove flags clear each other.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] IDX_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] IDX_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] IDX_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] IDX_MSTAT = 3'd3;
  localparam logic [ADDR_W-1:0] IDX_RAW   = 3'd4;
  localparam logic [ADDR_W-1:0] IDX_CARD  = 3'd5;

  localparam int NUM_EV = 5;
  // raw status bit positions, event order: no-resp, cmd, data, autostop, sdio
  localparam int EV_POS [NUM_EV] = '{1, 2, 3, 14, 16};
  localparam int BIT_DATA    = 3;
  localparam int BIT_INSERT  = 30;
  localparam int BIT_REMOVE  = 31;
  localparam int BIT_PRESENT = 8;
  localparam int BIT_IE      = 4;
  localparam int NUM_RST_REQ = 3;

  localparam logic [REG_W-1:0] CTRL_RST = 32'h0000_0300;
  localparam logic [REG_W-1:0] CARD_RST = 32'h0000_0100;

  // write-one-to-clear helper
  function automatic logic [REG_W-1:0] w1c(input logic [REG_W-1:0] cur,
                                           input logic             en,
                                           input logic [REG_W-1:0] ones);
    return en ? (cur & ~ones) : cur;
  endfunction

  // apply card edges to a raw word
  function automatic logic [REG_W-1:0] card_raw(input logic [REG_W-1:0] cur,
                                                input logic ins,
                                                input logic rem);
    logic [REG_W-1:0] r;
    r = cur;
    if (ins) begin
      r[BIT_INSERT] = 1'b1;
      r[BIT_REMOVE] = 1'b0;
    end else if (rem) begin
      r[BIT_REMOVE] = 1'b1;
      r[BIT_INSERT] = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/sdh_cfg_regs.sv
module sdh_cfg_regs
  import sdh_irq_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int ACCESS_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_mask,
  input  logic             wr_count,
  input  logic [REG_W-1:0] wdata,
  input  logic             xfer_access,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] mask_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero_ev
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(ACCESS_BYTES);

  function automatic logic [CNT_W-1:0] sat_sub(input logic [CNT_W-1:0] a);
    if (a > STEP) return a - STEP;
    return '0;
  endfunction

  logic [CNT_W-1:0] cnt_after;
  logic             do_access;

  assign do_access   = xfer_access && !wr_count;
  assign cnt_after   = sat_sub(cnt_q);
  assign cnt_zero_ev = do_access && (cnt_after == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      mask_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wdata;
        ctrl_q[NUM_RST_REQ-1:0] <= '0;
      end
      if (wr_mask) mask_q <= wdata;
      if (wr_count)       cnt_q <= wdata[CNT_W-1:0];
      else if (do_access) cnt_q <= cnt_after;
    end
  end
endmodule

// File: rtl/sdh_status_regs.sv
module sdh_status_regs
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_vec,
  input  logic              cnt_zero_ev,
  input  logic              card_detect,
  input  logic              clr_raw,
  input  logic              clr_card,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  raw_q,
  output logic [REG_W-1:0]  card_q,
  output logic              card_ins,
  output logic              card_rem
);
  logic             cd_prev;
  logic [REG_W-1:0] ev_bits;
  logic [REG_W-1:0] raw_nxt;
  logic [REG_W-1:0] card_nxt;

  always_comb begin
    ev_bits = '0;
    for (int i = 0; i < NUM_EV; i++)
      if (ev_vec[i]) ev_bits[EV_POS[i]] = 1'b1;
    if (cnt_zero_ev) ev_bits[BIT_DATA] = 1'b1;
  end

  assign card_ins = card_detect && !cd_prev;
  assign card_rem = !card_detect && cd_prev;

  always_comb begin
    raw_nxt  = card_raw(w1c(raw_q, clr_raw, wdata) | ev_bits, card_ins, card_rem);
    card_nxt = w1c(card_q, clr_card, wdata);
    if (card_ins) card_nxt[BIT_PRESENT] = 1'b1;
    if (card_rem) card_nxt[BIT_PRESENT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      card_q  <= CARD_RST;
      cd_prev <= 1'b1;
    end else begin
      raw_q   <= raw_nxt;
      card_q  <= card_nxt;
      cd_prev <= card_detect;
    end
  end
endmodule

// File: rtl/sdh_irq_out.sv
module sdh_irq_out
  import sdh_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ie,
  input  logic [REG_W-1:0] raw_q,
  input  logic [REG_W-1:0] mask_q,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= ie && (|(raw_q & mask_q));
  end
endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
  import sdh_irq_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int ACCESS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_no_resp,
  input  logic              ev_cmd_done,
  input  logic              ev_data_done,
  input  logic              ev_autostop_done,
  input  logic              ev_sdio_done,
  input  logic              card_detect,
  input  logic              xfer_access,
  output logic              irq
);
  logic [REG_W-1:0] ctrl_q, mask_q, raw_q, card_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero_ev, card_ins, card_rem;
  logic             wr_ctrl, wr_mask, wr_count, clr_raw, clr_card;
  logic [NUM_EV-1:0] ev_vec;

  assign wr_ctrl  = reg_we && (reg_addr == IDX_CTRL);
  assign wr_mask  = reg_we && (reg_addr == IDX_MASK);
  assign wr_count = reg_we && (reg_addr == IDX_COUNT);
  assign clr_raw  = reg_we && ((reg_addr == IDX_RAW) || (reg_addr == IDX_MSTAT));
  assign clr_card = reg_we && (reg_addr == IDX_CARD);
  assign ev_vec   = {ev_sdio_done, ev_autostop_done, ev_data_done, ev_cmd_done, ev_no_resp};

  sdh_cfg_regs #(.CNT_W(CNT_W), .ACCESS_BYTES(ACCESS_BYTES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
    .wr_count(wr_count), .wdata(reg_wdata), .xfer_access(xfer_access),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .cnt_q(cnt_q), .cnt_zero_ev(cnt_zero_ev)
  );

  sdh_status_regs u_stat (
    .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .cnt_zero_ev(cnt_zero_ev),
    .card_detect(card_detect), .clr_raw(clr_raw), .clr_card(clr_card),
    .wdata(reg_wdata), .raw_q(raw_q), .card_q(card_q),
    .card_ins(card_ins), .card_rem(card_rem)
  );

  sdh_irq_out u_out (
    .clk(clk), .rst_n(rst_n), .ie(ctrl_q[BIT_IE]),
    .raw_q(raw_q), .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    unique case (reg_addr)
      IDX_CTRL:  reg_rdata = ctrl_q;
      IDX_COUNT: reg_rdata = REG_W'(cnt_q);
      IDX_MASK:  reg_rdata = mask_q;
      IDX_MSTAT: reg_rdata = raw_q & mask_q;
      IDX_RAW:   reg_rdata = raw_q;
      IDX_CARD:  reg_rdata = card_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdh_irq_ctrl_chk.sv
module sdh_irq_ctrl_chk
  import sdh_irq_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int ACCESS_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              ev_cmd_done,
  input logic              any_ev,
  input logic              xfer_access,
  input logic              irq,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [REG_W-1:0]  mask_q,
  input logic [REG_W-1:0]  raw_q,
  input logic [REG_W-1:0]  card_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              card_ins,
  input logic              card_rem
);
  // R2
  a_r2_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(ctrl_q[BIT_IE] && (|(raw_q & mask_q))));
  // R6
  a_r6_insert: assert property (@(posedge clk) disable iff (!rst_n)
    card_ins |=> raw_q[BIT_INSERT] && !raw_q[BIT_REMOVE] && card_q[BIT_PRESENT]);
  a_r6_remove: assert property (@(posedge clk) disable iff (!rst_n)
    card_rem |=> raw_q[BIT_REMOVE] && !raw_q[BIT_INSERT] && !card_q[BIT_PRESENT]);
  // R4
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == IDX_RAW || reg_addr == IDX_MSTAT) && !any_ev
     && !xfer_access && !card_ins && !card_rem)
    |=> (raw_q & $past(reg_wdata)) == '0);
  // R10
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_done |=> raw_q[2]);
  // R7
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_access && !(reg_we && reg_addr == IDX_COUNT) && cnt_q <= CNT_W'(ACCESS_BYTES))
    |=> (cnt_q == '0) && raw_q[BIT_DATA]);
  // R9
  a_r9_rst_req_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[NUM_RST_REQ-1:0] == '0);
endmodule

bind sdh_irq_ctrl sdh_irq_ctrl_chk #(.CNT_W(CNT_W), .ACCESS_BYTES(ACCESS_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ev_cmd_done(ev_cmd_done), .any_ev(|ev_vec),
  .xfer_access(xfer_access), .irq(irq), .ctrl_q(ctrl_q), .mask_q(mask_q),
  .raw_q(raw_q), .card_q(card_q), .cnt_q(cnt_q),
  .card_ins(card_ins), .card_rem(card_rem)
);

// File: tb/sdh_irq_ctrl_test.sv
`timescale 1ns/1ps
module sdh_irq_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ev_no_resp = 0, ev_cmd_done = 0, ev_data_done = 0, ev_autostop_done = 0, ev_sdio_done = 0;
  logic card_detect = 1, xfer_access = 0, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  sdh_irq_ctrl uut (.*);

  always #2.5 clk = ~clk;

  // behavioural reference model
  bit [31:0] m_ctrl, m_mask, m_raw, m_card;
  longint    m_cnt;
  bit        m_irq, m_cd;

  always @(posedge clk) begin
    bit [31:0] raw, card;
    bit nirq;
    if (!rst_n) begin
      m_ctrl = 32'h300; m_mask = 0; m_raw = 0; m_card = 32'h100;
      m_cnt = 0; m_irq = 0; m_cd = 1;
    end else begin
      nirq = m_ctrl[4] && ((m_raw & m_mask) != 0);
      raw = m_raw; card = m_card;
      if (reg_we && (reg_addr == 3 || reg_addr == 4)) raw &= ~reg_wdata;
      if (reg_we && reg_addr == 5) card &= ~reg_wdata;
      if (reg_we && reg_addr == 0) m_ctrl = reg_wdata & ~32'h7;
      if (reg_we && reg_addr == 2) m_mask = reg_wdata;
      if (reg_we && reg_addr == 1) m_cnt = reg_wdata;
      else if (xfer_access) begin
        m_cnt = (m_cnt > 4) ? m_cnt - 4 : 0;
        if (m_cnt == 0) raw[3] = 1;
      end
      if (ev_no_resp) raw[1] = 1;
      if (ev_cmd_done) raw[2] = 1;
      if (ev_data_done) raw[3] = 1;
      if (ev_autostop_done) raw[14] = 1;
      if (ev_sdio_done) raw[16] = 1;
      if (card_detect && !m_cd) begin raw[30] = 1; raw[31] = 0; card[8] = 1; end
      if (!card_detect && m_cd) begin raw[31] = 1; raw[30] = 0; card[8] = 0; end
      m_cd = card_detect;
      m_raw = raw; m_card = card; m_irq = nirq;
    end
  end

  function automatic bit [31:0] m_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return 32'(m_cnt);
      2: return m_mask;
      3: return m_raw & m_mask;
      4: return m_raw;
      5: return m_card;
      default: return 0;
    endcase
  endfunction

  // R2: irq compared every cycle
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL R2 irq at %0t: actual %0b expected %0b", $time, irq, m_irq);
    end
  end

  task automatic chk(input string req, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    chk(req, reg_rdata, m_read(a));
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 8; a++) rd(a, "R1 reset value");
    chk("R1 reset ctrl", m_read(0), 32'h300);
    chk("R1 reset card", m_read(5), 32'h100);
    // R9: reset request bits read as 0
    wr(0, 32'hFFFF_FFFF); rd(0, "R9 ctrl write");
    chk("R9 ctrl literal", reg_rdata, 32'hFFFF_FFF8);
    wr(0, 32'h10);
    // R5, R3: single event, masked
    wr(2, 32'h4);
    @(negedge clk); ev_cmd_done = 1; @(negedge clk); ev_cmd_done = 0;
    idle(2);
    rd(4, "R5 cmd bit"); chk("R5 cmd literal", reg_rdata, 32'h4);
    rd(3, "R3 masked");
    chk("R2 irq high", {31'b0, irq}, 1);
    // R4: clear via masked index
    wr(3, 32'h4); idle(2);
    rd(4, "R4 cleared");
    // R5: several events at once
    @(negedge clk);
    ev_no_resp = 1; ev_data_done = 1; ev_autostop_done = 1; ev_sdio_done = 1;
    @(negedge clk);
    ev_no_resp = 0; ev_data_done = 0; ev_autostop_done = 0; ev_sdio_done = 0;
    rd(4, "R5 multi"); chk("R5 multi literal", reg_rdata, 32'h0001_400A);
    rd(3, "R3 masked multi");
    wr(2, 32'h0001_0000); idle(2); rd(3, "R3 mask change");
    // R4: partial clear via raw index
    wr(4, 32'h0000_4002); rd(4, "R4 partial"); chk("R4 partial literal", reg_rdata, 32'h0001_0008);
    // R2: global enable off
    wr(0, 32'h0); idle(2); chk("R2 disabled", {31'b0, irq}, 0);
    wr(0, 32'h10); idle(2);
    // R10: event with clear same cycle
    @(negedge clk);
    reg_we = 1; reg_addr = 4; reg_wdata = 32'hFFFF_FFFF; ev_cmd_done = 1;
    @(negedge clk);
    reg_we = 0; ev_cmd_done = 0;
    rd(4, "R10 event wins"); chk("R10 literal", reg_rdata, 32'h4);
    wr(4, 32'hFFFF_FFFF);
    // R6: removal then insertion
    wr(2, 32'hC000_0000);
    @(negedge clk); card_detect = 0; idle(2);
    rd(4, "R6 remove raw"); chk("R6 remove literal", reg_rdata, 32'h8000_0000);
    rd(5, "R6 remove card");
    @(negedge clk); card_detect = 1; idle(2);
    rd(4, "R6 insert raw"); chk("R6 insert literal", reg_rdata, 32'h4000_0000);
    rd(5, "R6 insert card");
    // R8: card status write-one-to-clear
    wr(5, 32'h100); rd(5, "R8 card clear"); chk("R8 literal", reg_rdata, 0);
    // R10: card edge with clear of the same bit
    @(negedge clk); card_detect = 0;
    reg_we = 1; reg_addr = 4; reg_wdata = 32'h8000_0000;
    @(negedge clk); reg_we = 0;
    rd(4, "R10 card edge wins");
    wr(4, 32'hFFFF_FFFF); card_detect = 1; idle(2); wr(4, 32'hFFFF_FFFF);
    // R7: counter
    wr(2, 32'h8);
    wr(1, 10); rd(1, "R7 load");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); xfer_access = 1; @(negedge clk); xfer_access = 0;
      rd(1, "R7 count"); rd(4, "R7 data bit");
    end
    chk("R7 zero literal", m_read(1), 0);
    wr(4, 32'h8);
    @(negedge clk); xfer_access = 1; @(negedge clk); xfer_access = 0;
    rd(4, "R7 access at zero"); chk("R7 zero access literal", reg_rdata, 32'h8);
    wr(4, 32'h8);
    // R7: load wins over access
    @(negedge clk);
    reg_we = 1; reg_addr = 1; reg_wdata = 32'd20; xfer_access = 1;
    @(negedge clk); reg_we = 0; xfer_access = 0;
    rd(1, "R7 load wins"); chk("R7 load literal", reg_rdata, 20);
    rd(4, "R7 no data bit on load");
    wr(1, 0); rd(4, "R7 load zero no event");
    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule